// File: doc/BRIEF.md
# SIMD Processor-Enable Mask Unit

This block owns the enable vector of an array of N = 2^n processing elements, numbered 0 to N-1. Element i executes broadcast work exactly when bit i of the enable vector is 1. A control sequencer drives one command per cycle, made of an opcode and an N-bit operand. A command can load a full N-bit mask unchanged, or decode a compact ternary address mask into an N-bit vector. The decoded vector can replace the current enable vector or be merged into it by OR (union of element sets) or AND (intersection).

For nested data-dependent regions, the unit keeps a stack of masks, and the top entry is always the live enable vector. The elements return one true/false condition bit each. The unit captures that vector and can push the current mask narrowed to the elements whose bit is true, or to those whose bit is false. A pop restores the enclosing region. Two flags, "any" and "all", are computed continuously from the captured condition vector and the live enable vector, and feed branch decisions in the sequencer.

Top module: `mask_unit`

## Requirements
- R1: After reset the stack holds one all-ones entry, so en_o is all ones, the captured condition vector is zero, err_o is 0, any_o is 0 and all_o is 0.
- R2: Opcode 1 (load general) makes en_o equal opnd_i from the next cycle on, with no change to any bit.
- R3: Opcode 2 (load address) replaces the top with the decoded ternary mask in opnd_i[2n-1:0]. Address bit j is governed by the field at opnd_i[2j+1:2j]: 00 requires bit j of the element number to be 0, 01 requires it to be 1, and 1x is don't-care. An element is enabled when every field matches its number.
- R4: Opcode 3 ORs the decoded address mask into the top, and opcode 4 ANDs it into the top.
- R5: When cond_valid_i is high, cond_i is captured at the clock edge. Any command in the same cycle uses the previously captured vector.
- R6: Opcode 5 pushes (top AND captured condition), and opcode 6 pushes (top AND NOT captured condition). The new entry becomes en_o and the old top is kept below it.
- R7: Opcode 7 pops, and en_o returns to the entry below.
- R8: A push while DEPTH entries are held, or a pop while only one entry is held, leaves en_o unchanged and sets err_o. err_o stays set until reset.
- R9: any_o is 1 when some enabled element has its captured condition bit set. all_o is 1 when every enabled element has its bit set, with disabled elements counting as satisfied. When no element is enabled, all_o is 1 and any_o is 0.
- R10: Opcode 0, or any cycle with cmd_valid_i low, leaves en_o and err_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Command present this cycle |
| op_i | input | 3 | Command opcode |
| opnd_i | input | N | General mask, or ternary address mask in the low 2n bits |
| cond_valid_i | input | 1 | Capture cond_i this cycle |
| cond_i | input | N | Per-element true/false condition results |
| en_o | output | N | Live enable vector (top of stack) |
| any_o | output | 1 | Some enabled element has its condition true |
| all_o | output | 1 | Every enabled element has its condition true |
| err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench aims at the ternary field decoding, where a swapped field order or a misread don't-care would enable a mirrored or wrong element set. It also targets a capture and a push in the same cycle, which a wrong design would resolve with the new condition instead of the held one. It drives the stack to full and to its last entry, where a faulty pointer would wrap or corrupt the enable vector instead of holding it and raising the error. It clears the enable vector completely to check that "all" counts disabled elements as satisfied rather than reporting false.

// File: rtl/mask_unit_pkg.sv
package mask_unit_pkg;
  typedef enum logic [2:0] {
    OP_NOP       = 3'd0,
    OP_LOAD_GEN  = 3'd1,
    OP_LOAD_ADDR = 3'd2,
    OP_OR_ADDR   = 3'd3,
    OP_AND_ADDR  = 3'd4,
    OP_PUSH_T    = 3'd5,
    OP_PUSH_F    = 3'd6,
    OP_POP       = 3'd7
  } mask_op_e;
endpackage

// File: rtl/mask_addr_decode.sv
module mask_addr_decode #(
  parameter int LOG_N = 4,
  localparam int N = 1 << LOG_N,
  localparam int AW = 2 * LOG_N
) (
  input  logic [AW-1:0] amask_i,
  output logic [N-1:0]  vec_o
);
  for (genvar i = 0; i < N; i++) begin : g_elem
    localparam logic [LOG_N-1:0] IDX = LOG_N'(i);
    logic [LOG_N-1:0] hit;
    for (genvar j = 0; j < LOG_N; j++) begin : g_pos
      // field 1x = don't care, else low bit is the required value
      assign hit[j] = amask_i[2*j+1] | (amask_i[2*j] == IDX[j]);
    end
    assign vec_o[i] = &hit;
  end
endmodule

// File: rtl/mask_stack.sv
module mask_stack #(
  parameter int N = 16,
  parameter int DEPTH = 4,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [N-1:0] data_i,
  output logic [N-1:0] top_o,
  output logic         full_o,
  output logic         last_o,
  output logic         err_o
);
  logic [N-1:0]  mem [DEPTH];
  logic [PW-1:0] sp_q;
  logic          err_q;

  assign full_o = (sp_q == PW'(DEPTH - 1));
  assign last_o = (sp_q == '0);
  assign top_o  = mem[sp_q];
  assign err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sp_q  <= '0;
      err_q <= 1'b0;
      for (int k = 0; k < DEPTH; k++) mem[k] <= '1;
    end else if (push_i) begin
      if (full_o) err_q <= 1'b1;
      else begin
        sp_q            <= sp_q + PW'(1);
        mem[sp_q+PW'(1)] <= data_i;
      end
    end else if (pop_i) begin
      if (last_o) err_q <= 1'b1;
      else sp_q <= sp_q - PW'(1);
    end else if (wr_i) begin
      mem[sp_q] <= data_i;
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
  AST_UNDERFLOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && last_o) |=> (err_o && top_o == $past(top_o))); // R8
endmodule

// File: rtl/mask_cond_eval.sv
module mask_cond_eval #(
  parameter int N = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cond_valid_i,
  input  logic [N-1:0] cond_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] cond_q_o,
  output logic         any_o,
  output logic         all_o
);
  logic [N-1:0] cond_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cond_q <= '0;
    else if (cond_valid_i) cond_q <= cond_i;
  end

  assign cond_q_o = cond_q;
  assign any_o    = |(cond_q & en_i);
  assign all_o    = &(cond_q | ~en_i);

  AST_ALL_GIVES_ANY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_o && (en_i != '0)) |-> any_o); // R9
  AST_NONE_ENABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> (all_o && !any_o)); // R9
endmodule

// File: rtl/mask_unit.sv
module mask_unit
  import mask_unit_pkg::*;
#(
  parameter int LOG_N = 4,
  parameter int DEPTH = 4,
  localparam int N = 1 << LOG_N,
  localparam int AW = 2 * LOG_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cmd_valid_i,
  input  logic [2:0]   op_i,
  input  logic [N-1:0] opnd_i,
  input  logic         cond_valid_i,
  input  logic [N-1:0] cond_i,
  output logic [N-1:0] en_o,
  output logic         any_o,
  output logic         all_o,
  output logic         err_o
);
  mask_op_e     op;
  logic [N-1:0] dec_vec, top, cond_q, wdata;
  logic         wr, push, pop, full, last;

  assign op = mask_op_e'(op_i);

  mask_addr_decode #(.LOG_N(LOG_N)) u_dec (
    .amask_i (opnd_i[AW-1:0]),
    .vec_o   (dec_vec)
  );

  always_comb begin
    wr    = 1'b0;
    push  = 1'b0;
    pop   = 1'b0;
    wdata = top;
    if (cmd_valid_i) begin
      unique case (op)
        OP_LOAD_GEN:  begin wr = 1'b1;   wdata = opnd_i;          end
        OP_LOAD_ADDR: begin wr = 1'b1;   wdata = dec_vec;         end
        OP_OR_ADDR:   begin wr = 1'b1;   wdata = top | dec_vec;   end
        OP_AND_ADDR:  begin wr = 1'b1;   wdata = top & dec_vec;   end
        OP_PUSH_T:    begin push = 1'b1; wdata = top & cond_q;    end
        OP_PUSH_F:    begin push = 1'b1; wdata = top & ~cond_q;   end
        OP_POP:       pop = 1'b1;
        default:      ;
      endcase
    end
  end

  mask_stack #(.N(N), .DEPTH(DEPTH)) u_stk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (wr),
    .push_i (push),
    .pop_i  (pop),
    .data_i (wdata),
    .top_o  (top),
    .full_o (full),
    .last_o (last),
    .err_o  (err_o)
  );

  mask_cond_eval #(.N(N)) u_cond (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cond_valid_i (cond_valid_i),
    .cond_i       (cond_i),
    .en_i         (top),
    .cond_q_o     (cond_q),
    .any_o        (any_o),
    .all_o        (all_o)
  );

  assign en_o = top;

  AST_LOAD_GEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && op_i == 3'd1) |=> (en_o == $past(opnd_i))); // R2
  AST_PUSH_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (op_i == 3'd5 || op_i == 3'd6) && !full)
      |=> ((en_o & ~$past(en_o)) == '0)); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && (op_i == 3'd5 || op_i == 3'd6) && full)
      |=> (err_o && en_o == $past(en_o))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_valid_i || op_i == 3'd0) |=> (en_o == $past(en_o) && err_o == $past(err_o))); // R10
endmodule

// File: tb/tb_mask_unit.sv
`timescale 1ns/1ps
module tb_mask_unit;
  localparam int LOG_N = 4;
  localparam int DEPTH = 4;
  localparam int N = 1 << LOG_N;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [2:0]   op = '0;
  logic [N-1:0] opnd = '0;
  logic         cond_valid = 1'b0;
  logic [N-1:0] cond = '0;
  logic [N-1:0] en;
  logic         any_f, all_f, err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [N-1:0] m_stk [DEPTH];
  int           m_sp;
  logic         m_err;
  logic [N-1:0] m_cond;

  always #2.5 clk = ~clk;

  mask_unit #(.LOG_N(LOG_N), .DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .op_i(op),
    .opnd_i(opnd), .cond_valid_i(cond_valid), .cond_i(cond),
    .en_o(en), .any_o(any_f), .all_o(all_f), .err_o(err)
  );

  function automatic logic [N-1:0] dec_ref(input logic [N-1:0] a);
    logic [N-1:0] v = '0;
    for (int i = 0; i < N; i++) begin
      bit ok = 1'b1;
      for (int j = 0; j < LOG_N; j++)
        if (!a[2*j+1] && (a[2*j] != ((i >> j) & 1))) ok = 1'b0;
      v[i] = ok;
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    logic [N-1:0] t = m_stk[m_sp];
    chk({req, " en"}, en, t);
    chk({req, " any (R9)"}, N'(any_f), N'(|(m_cond & t)));
    chk({req, " all (R9)"}, N'(all_f), N'(&(m_cond | ~t)));
    chk({req, " err (R8)"}, N'(err), N'(m_err));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0; cond_valid = 1'b0;
    for (int k = 0; k < DEPTH; k++) m_stk[k] = '1;
    m_sp = 0; m_err = 1'b0; m_cond = '0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 reset");
  endtask

  task automatic step(input logic v, input logic [2:0] o, input logic [N-1:0] a,
                      input logic cv, input logic [N-1:0] c, input string req);
    logic [N-1:0] t = m_stk[m_sp];
    cmd_valid = v; op = o; opnd = a; cond_valid = cv; cond = c;
    if (v) begin
      case (o)
        3'd1: m_stk[m_sp] = a;
        3'd2: m_stk[m_sp] = dec_ref(a);
        3'd3: m_stk[m_sp] = t | dec_ref(a);
        3'd4: m_stk[m_sp] = t & dec_ref(a);
        3'd5, 3'd6: begin
          if (m_sp == DEPTH - 1) m_err = 1'b1;
          else begin
            m_sp++;
            m_stk[m_sp] = (o == 3'd5) ? (t & m_cond) : (t & ~m_cond);
          end
        end
        3'd7: if (m_sp == 0) m_err = 1'b1; else m_sp--;
        default: ;
      endcase
    end
    if (cv) m_cond = c;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cond_valid = 1'b0;
    check_all(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog all-reqs actual=timeout expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    step(1, 3'd1, 16'hA5A5, 0, '0, "R2 load general");
    chk("R2 exact", en, 16'hA5A5);
    // fields {p3,p2,p1,p0} = 10,01,11,00 -> bit2=1, bit0=0
    step(1, 3'd2, 16'h009C, 0, '0, "R3 load address");
    chk("R3 decode", en, 16'h5050);
    step(1, 3'd3, 16'h0000, 0, '0, "R4 or element0");
    chk("R4 union", en, 16'h5051);
    step(1, 3'd4, 16'h00A9, 0, '0, "R4 and odd");
    chk("R4 intersection", en, 16'h0000);
    chk("R9 none enabled", {any_f, all_f}, 2'b01);
    step(1, 3'd2, 16'h00AA, 0, '0, "R3 all dont care");
    chk("R3 all dc", en, 16'hFFFF);
    step(0, 3'd1, 16'h1234, 1, 16'h00FF, "R5 capture R10 idle");
    chk("R10 idle", en, 16'hFFFF);
    // capture new cond with push: push must use 00FF
    step(1, 3'd5, '0, 1, 16'h0F0F, "R5 same-cycle push R6");
    chk("R6 push true", en, 16'h00FF);
    step(1, 3'd6, '0, 0, '0, "R6 push false");
    chk("R6 push false", en, 16'h00F0);
    step(1, 3'd0, 16'hFFFF, 0, '0, "R10 nop");
    step(1, 3'd7, '0, 0, '0, "R7 pop");
    chk("R7 pop", en, 16'h00FF);
    step(1, 3'd7, '0, 0, '0, "R7 pop2");
    step(1, 3'd7, '0, 0, '0, "R8 underflow");
    chk("R8 underflow err", N'(err), N'(1));
    do_reset();
    for (int k = 0; k < DEPTH; k++)
      step(1, 3'd5, '0, 1, 16'hFFFE >> k, "R8 fill R6");
    chk("R8 overflow err", N'(err), N'(1));
    step(1, 3'd1, 16'h3C3C, 0, '0, "R8 sticky R2");
    for (int s = 0; s < 400; s++) begin
      logic [2:0] o = 3'($urandom);
      string tg;
      case (o)
        3'd0: tg = "R10 rnd"; 3'd1: tg = "R2 rnd"; 3'd2: tg = "R3 rnd";
        3'd3, 3'd4: tg = "R4 rnd"; 3'd5, 3'd6: tg = "R6 rnd";
        default: tg = "R7 rnd";
      endcase
      if (s % 97 == 96) do_reset();
      step(($urandom % 8) != 0, o, N'($urandom), ($urandom % 3) == 0, N'($urandom), tg);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule